// File: doc/BRIEF.md
# Set-Associative Translation Array with Round-Robin Replacement

This block holds page translations in a set-associative array of 128 sets with four ways, or two when the way-count parameter is set to 2. A command port carries one operation per cycle: write an entry, read an entry back, or search a set for a page. The set index is the low seven bits of the effective page number, and the remaining page-number bits form the stored tag. Each command leaves its result in a bank of output registers one cycle later. The output registers have the same shape as the command fields: a way select, a next-victim value, a hit flag, a valid bit, a page number and a data word.

Each set has its own round-robin pointer that names the way to replace next. Software never computes this pointer. The block reports it after every write, read and search. It also reports it when a lookup on the separate translation port misses, so that a refill handler can pass the reported way straight back into the next write. The translation port accepts one lookup per cycle and returns hit and data one cycle later.

Top module: `tlb_rr_array`

## Requirements
- R1: After synchronous reset, every entry reads back with valid 0, tag 0 and data 0, and every round-robin pointer is 0. All response outputs and `lk_hit`/`lk_data` are 0.
- R2: `cmd_op` encodes 0 = idle, 1 = write, 2 = read, 3 = search. A write stores `cmd_vbit`, the tag `cmd_vpn[19:7]` and `cmd_data` in set `cmd_vpn[6:0]`, in the way given by the low way-select bits of `cmd_esel`. On the next cycle the outputs show `out_esel` = that way, `out_hit` = 0, and the written valid bit, page number and data.
- R3: A write into the way a set's pointer names advances that pointer by one, wrapping modulo the way count. A write into any other way leaves the pointer unchanged. `out_nv` after a write shows the updated pointer.
- R4: A read returns the selected entry's valid bit and data, with `out_vpn` = {stored tag, set}. It also returns `out_esel` = the selected way and `out_nv` = the set's pointer.
- R5: A search whose tag matches a valid entry gives `out_hit` = 1, `out_vbit` = 1, `out_esel` = the matching way, that entry's data, and `out_nv` = the set's pointer. When several ways match, the lowest-numbered way wins.
- R6: A search miss gives `out_hit` = 0, `out_vbit` = 0, `out_data` = 0, `out_vpn` = the searched page, and `out_esel` = `out_nv` = the set's pointer. An entry with a matching tag but valid 0 does not hit.
- R7: A lookup presented with `lk_req` gives `lk_hit` and `lk_data` (data is 0 on a miss) on the next cycle. A lookup sees the array as it was before a write in the same cycle.
- R8: A lookup miss in a cycle with an idle command port loads `out_esel` = `out_nv` = the pointer of the lookup's set, `out_hit` = 0, `out_vbit` = 0, `out_data` = 0, and `out_vpn` = the missed page.
- R9: When a command and a lookup miss fall in the same cycle, the response outputs carry the command's result.
- R10: Way-select bits above the way-index bits (bits 3:2 for four ways, bits 3:1 for two ways) are ignored. The matching output bits of `out_esel`, and `out_nv[1]` in the two-way configuration, stay 0.
- R11: An idle cycle with no lookup miss leaves all response outputs unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_op | input | 2 | Command: 0 idle, 1 write, 2 read, 3 search |
| cmd_esel | input | 4 | Way select for write and read |
| cmd_vpn | input | 20 | Page number: bits 6:0 are the set, bits 19:7 the tag |
| cmd_vbit | input | 1 | Valid bit to write |
| cmd_data | input | 16 | Data to write |
| lk_req | input | 1 | Translation lookup request |
| lk_vpn | input | 20 | Page number to translate |
| lk_hit | output | 1 | Lookup hit, one cycle after the request |
| lk_data | output | 16 | Data of the hitting entry, else 0 |
| out_esel | output | 4 | Reported way select |
| out_nv | output | 2 | Reported next-victim way |
| out_hit | output | 1 | Search hit flag |
| out_vbit | output | 1 | Reported valid bit |
| out_vpn | output | 20 | Reported page number |
| out_data | output | 16 | Reported data |

## Verification
The response registers can be claimed in the same cycle by a command and by a lookup miss on the translation port. A lookup can also read a set while a write to that same set lands. The bench provokes both cases on purpose: it issues a search together with a missing lookup, and a write together with a lookup of the page being written. Afterwards it expects the command's result in the response registers, a miss on that lookup, and a hit on the following lookup. A behavioural model of both the four-way and the two-way instance is compared on every cycle, through directed and pseudo-random traffic.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VPN_W    = 20;
    localparam int SET_BITS = 7;
    localparam int DATA_W   = 16;
    localparam int ESEL_W   = 4;
    localparam int NV_W     = 2;
    localparam int TAG_W    = VPN_W - SET_BITS;
    localparam int SETS     = 1 << SET_BITS;

    typedef enum logic [1:0] {
        OP_IDLE   = 2'b00,
        OP_WRITE  = 2'b01,
        OP_READ   = 2'b10,
        OP_SEARCH = 2'b11
    } tlb_op_e;

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [DATA_W-1:0] data;
    } tlb_entry_t;

    typedef struct packed {
        logic [ESEL_W-1:0] esel;
        logic [NV_W-1:0]   nv;
        logic              hit;
        logic              vbit;
        logic [VPN_W-1:0]  vpn;
        logic [DATA_W-1:0] data;
    } tlb_resp_t;

    // Round-robin successor of a way pointer, wrapping at the way count.
    function automatic logic [NV_W-1:0] ptr_step(input logic [NV_W-1:0] cur,
                                                 input int nways);
        if (int'(cur) >= nways - 1)
            return '0;
        return cur + NV_W'(1);
    endfunction

endpackage

// File: rtl/tlb_way_bank.sv
module tlb_way_bank
    import tlb_pkg::*;
(
    input  logic                clk,
    input  logic                rst,
    input  logic                we,
    input  logic [SET_BITS-1:0] wr_set,
    input  tlb_entry_t          wr_entry,
    input  logic [SET_BITS-1:0] rd_set_a,
    output tlb_entry_t          rd_a,
    input  logic [SET_BITS-1:0] rd_set_b,
    output tlb_entry_t          rd_b
);

    tlb_entry_t mem_q [SETS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                mem_q[s] <= '0;
        end else if (we) begin
            mem_q[wr_set] <= wr_entry;
        end
    end

    assign rd_a = mem_q[rd_set_a];
    assign rd_b = mem_q[rd_set_b];

    // R2: a written entry is held in its set from the next cycle on
    assert_bank_store_R2: assert property (@(posedge clk) disable iff (rst)
        we |=> mem_q[$past(wr_set)] == $past(wr_entry));

endmodule

// File: rtl/tlb_victim_ptr.sv
module tlb_victim_ptr
    import tlb_pkg::*;
#(
    parameter int NUM_WAYS = 4
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [SET_BITS-1:0] wr_set,
    input  logic [NV_W-1:0]     wr_way,
    input  logic [SET_BITS-1:0] rd_set_a,
    output logic [NV_W-1:0]     ptr_a,
    input  logic [SET_BITS-1:0] rd_set_b,
    output logic [NV_W-1:0]     ptr_b
);

    logic [NV_W-1:0] ptr_q [SETS];
    logic            fill_victim;

    assign fill_victim = wr_en && (wr_way == ptr_q[wr_set]);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++)
                ptr_q[s] <= '0;
        end else if (fill_victim) begin
            ptr_q[wr_set] <= ptr_step(ptr_q[wr_set], NUM_WAYS);
        end
    end

    assign ptr_a = ptr_q[rd_set_a];
    assign ptr_b = ptr_q[rd_set_b];

    // R3: filling the pointed way moves the pointer
    assert_ptr_moves_R3: assert property (@(posedge clk) disable iff (rst)
        fill_victim |=> ptr_q[$past(wr_set)] != $past(ptr_q[wr_set]));

    // R3: filling another way leaves the pointer alone
    assert_ptr_kept_R3: assert property (@(posedge clk) disable iff (rst)
        (wr_en && !fill_victim) |=> ptr_q[$past(wr_set)] == $past(ptr_q[wr_set]));

    // R10: pointers never name a way that does not exist
    assert_ptr_range_R10: assert property (@(posedge clk) disable iff (rst)
        (int'(ptr_a) < NUM_WAYS) && (int'(ptr_b) < NUM_WAYS));

endmodule

// File: rtl/tlb_match.sv
module tlb_match
    import tlb_pkg::*;
#(
    parameter int NUM_WAYS = 4
) (
    input  tlb_entry_t       ents [NUM_WAYS],
    input  logic [TAG_W-1:0] tag,
    output logic             hit,
    output logic [NV_W-1:0]  way
);

    // Scan from the top way down so the lowest matching way is kept.
    always_comb begin
        hit = 1'b0;
        way = '0;
        for (int w = NUM_WAYS - 1; w >= 0; w--) begin
            if (ents[w].valid && (ents[w].tag == tag)) begin
                hit = 1'b1;
                way = NV_W'(w);
            end
        end
    end

endmodule

// File: rtl/tlb_rr_array.sv
module tlb_rr_array
    import tlb_pkg::*;
#(
    parameter int NUM_WAYS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [1:0]        cmd_op,
    input  logic [3:0]        cmd_esel,
    input  logic [19:0]       cmd_vpn,
    input  logic              cmd_vbit,
    input  logic [15:0]       cmd_data,
    input  logic              lk_req,
    input  logic [19:0]       lk_vpn,
    output logic              lk_hit,
    output logic [15:0]       lk_data,
    output logic [3:0]        out_esel,
    output logic [1:0]        out_nv,
    output logic              out_hit,
    output logic              out_vbit,
    output logic [19:0]       out_vpn,
    output logic [15:0]       out_data
);

    localparam logic [ESEL_W-1:0] WAY_MASK = ESEL_W'(NUM_WAYS - 1);

    tlb_op_e             op;
    logic [SET_BITS-1:0] c_set, l_set;
    logic [TAG_W-1:0]    c_tag, l_tag;
    logic [NV_W-1:0]     c_way;
    tlb_entry_t          wr_ent;
    logic                wr_any;

    assign op     = tlb_op_e'(cmd_op);
    assign c_set  = cmd_vpn[SET_BITS-1:0];
    assign c_tag  = cmd_vpn[VPN_W-1:SET_BITS];
    assign l_set  = lk_vpn[SET_BITS-1:0];
    assign l_tag  = lk_vpn[VPN_W-1:SET_BITS];
    assign c_way  = NV_W'(cmd_esel & WAY_MASK);
    assign wr_any = (op == OP_WRITE);
    assign wr_ent = '{valid: cmd_vbit, tag: c_tag, data: cmd_data};

    // ---------------- storage, one bank per way ----------------
    tlb_entry_t c_ents [NUM_WAYS];
    tlb_entry_t l_ents [NUM_WAYS];

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        tlb_way_bank u_bank (
            .clk      (clk),
            .rst      (rst),
            .we       (wr_any && (c_way == NV_W'(w))),
            .wr_set   (c_set),
            .wr_entry (wr_ent),
            .rd_set_a (c_set),
            .rd_a     (c_ents[w]),
            .rd_set_b (l_set),
            .rd_b     (l_ents[w])
        );
    end

    // ---------------- replacement pointers ----------------
    logic [NV_W-1:0] ptr_c, ptr_l, ptr_after_wr;

    tlb_victim_ptr #(.NUM_WAYS(NUM_WAYS)) u_ptr (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (wr_any),
        .wr_set   (c_set),
        .wr_way   (c_way),
        .rd_set_a (c_set),
        .ptr_a    (ptr_c),
        .rd_set_b (l_set),
        .ptr_b    (ptr_l)
    );

    assign ptr_after_wr = (c_way == ptr_c) ? ptr_step(ptr_c, NUM_WAYS) : ptr_c;

    // ---------------- tag compare ----------------
    logic            s_hit, l_hit;
    logic [NV_W-1:0] s_way, l_way;

    tlb_match #(.NUM_WAYS(NUM_WAYS)) u_cmd_match (
        .ents (c_ents), .tag (c_tag), .hit (s_hit), .way (s_way));

    tlb_match #(.NUM_WAYS(NUM_WAYS)) u_lk_match (
        .ents (l_ents), .tag (l_tag), .hit (l_hit), .way (l_way));

    // ---------------- way selection muxes ----------------
    tlb_entry_t rd_ent, s_ent, l_ent;

    always_comb begin
        rd_ent = '0;
        s_ent  = '0;
        l_ent  = '0;
        for (int w = 0; w < NUM_WAYS; w++) begin
            if (c_way == NV_W'(w)) rd_ent = c_ents[w];
            if (s_way == NV_W'(w)) s_ent  = c_ents[w];
            if (l_way == NV_W'(w)) l_ent  = l_ents[w];
        end
    end

    // ---------------- response registers ----------------
    tlb_resp_t resp_q, resp_d;
    logic      lk_hit_q;
    logic [DATA_W-1:0] lk_data_q;

    always_comb begin
        resp_d = resp_q;
        case (op)
            OP_WRITE: resp_d = '{esel: ESEL_W'(c_way), nv: ptr_after_wr, hit: 1'b0,
                                 vbit: cmd_vbit, vpn: cmd_vpn, data: cmd_data};
            OP_READ:  resp_d = '{esel: ESEL_W'(c_way), nv: ptr_c, hit: 1'b0,
                                 vbit: rd_ent.valid, vpn: {rd_ent.tag, c_set},
                                 data: rd_ent.data};
            OP_SEARCH: begin
                if (s_hit)
                    resp_d = '{esel: ESEL_W'(s_way), nv: ptr_c, hit: 1'b1,
                               vbit: 1'b1, vpn: cmd_vpn, data: s_ent.data};
                else
                    resp_d = '{esel: ESEL_W'(ptr_c), nv: ptr_c, hit: 1'b0,
                               vbit: 1'b0, vpn: cmd_vpn, data: '0};
            end
            default: begin
                if (lk_req && !l_hit)
                    resp_d = '{esel: ESEL_W'(ptr_l), nv: ptr_l, hit: 1'b0,
                               vbit: 1'b0, vpn: lk_vpn, data: '0};
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            resp_q    <= '0;
            lk_hit_q  <= 1'b0;
            lk_data_q <= '0;
        end else begin
            resp_q    <= resp_d;
            lk_hit_q  <= lk_req && l_hit;
            lk_data_q <= (lk_req && l_hit) ? l_ent.data : '0;
        end
    end

    assign out_esel = resp_q.esel;
    assign out_nv   = resp_q.nv;
    assign out_hit  = resp_q.hit;
    assign out_vbit = resp_q.vbit;
    assign out_vpn  = resp_q.vpn;
    assign out_data = resp_q.data;
    assign lk_hit   = lk_hit_q;
    assign lk_data  = lk_data_q;

    // ---------------- assertions ----------------
    // R1: first cycle out of reset shows a cleared response
    assert_reset_clear_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (out_esel == '0 && out_nv == '0 && !out_hit && !lk_hit));

    // R5: a reported hit always carries a valid entry
    assert_hit_valid_R5: assert property (@(posedge clk) disable iff (rst)
        out_hit |-> out_vbit);

    // R6: a search that missed names the victim in both fields
    assert_miss_victim_R6: assert property (@(posedge clk) disable iff (rst)
        ($past(op == OP_SEARCH) && !out_hit) |-> (out_esel == ESEL_W'(out_nv)));

    // R7: no lookup, no lookup hit
    assert_lk_idle_R7: assert property (@(posedge clk) disable iff (rst)
        $past(!lk_req) |-> !lk_hit);

    // R10: reported way fields stay within the configured ways
    assert_esel_range_R10: assert property (@(posedge clk) disable iff (rst)
        (int'(out_esel) < NUM_WAYS) && (int'(out_nv) < NUM_WAYS));

    // R11: a quiet cycle leaves the response untouched
    assert_idle_hold_R11: assert property (@(posedge clk) disable iff (rst)
        $past(op == OP_IDLE && !lk_req) |->
            ($stable(out_esel) && $stable(out_nv) && $stable(out_vpn) && $stable(out_data)));

endmodule

// File: tb/sim_tlb_rr_array.sv
`timescale 1ns/1ps
module sim_tlb_rr_array;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [1:0]  cmd_op = '0;
    logic [3:0]  cmd_esel = '0;
    logic [19:0] cmd_vpn = '0;
    logic        cmd_vbit = 1'b0;
    logic [15:0] cmd_data = '0;
    logic        lk_req = 1'b0;
    logic [19:0] lk_vpn = '0;

    logic        lk_hit [2];
    logic [15:0] lk_data [2];
    logic [3:0]  o_esel [2];
    logic [1:0]  o_nv [2];
    logic        o_hit [2];
    logic        o_vbit [2];
    logic [19:0] o_vpn [2];
    logic [15:0] o_data [2];

    always #2.5 clk = ~clk;

    tlb_rr_array #(.NUM_WAYS(4)) u0 (
        .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_esel(cmd_esel), .cmd_vpn(cmd_vpn),
        .cmd_vbit(cmd_vbit), .cmd_data(cmd_data), .lk_req(lk_req), .lk_vpn(lk_vpn),
        .lk_hit(lk_hit[0]), .lk_data(lk_data[0]), .out_esel(o_esel[0]), .out_nv(o_nv[0]),
        .out_hit(o_hit[0]), .out_vbit(o_vbit[0]), .out_vpn(o_vpn[0]), .out_data(o_data[0]));

    tlb_rr_array #(.NUM_WAYS(2)) u1 (
        .clk(clk), .rst(rst), .cmd_op(cmd_op), .cmd_esel(cmd_esel), .cmd_vpn(cmd_vpn),
        .cmd_vbit(cmd_vbit), .cmd_data(cmd_data), .lk_req(lk_req), .lk_vpn(lk_vpn),
        .lk_hit(lk_hit[1]), .lk_data(lk_data[1]), .out_esel(o_esel[1]), .out_nv(o_nv[1]),
        .out_hit(o_hit[1]), .out_vbit(o_vbit[1]), .out_vpn(o_vpn[1]), .out_data(o_data[1]));

    // ---------------- behavioural reference ----------------
    int nw [2] = '{4, 2};
    int mv [2][128][4];
    int mt [2][128][4];
    int md [2][128][4];
    int mp [2][128];
    int e_esel [2], e_nv [2], e_hit [2], e_vbit [2], e_vpn [2], e_data [2];
    int e_lkh [2], e_lkd [2];

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic compare_all(input string req, input string lreq);
        for (int d = 0; d < 2; d++) begin
            chk(req,  $sformatf("w%0d out_esel", nw[d]), int'(o_esel[d]), e_esel[d]);
            chk(req,  $sformatf("w%0d out_nv",   nw[d]), int'(o_nv[d]),   e_nv[d]);
            chk(req,  $sformatf("w%0d out_hit",  nw[d]), int'(o_hit[d]),  e_hit[d]);
            chk(req,  $sformatf("w%0d out_vbit", nw[d]), int'(o_vbit[d]), e_vbit[d]);
            chk(req,  $sformatf("w%0d out_vpn",  nw[d]), int'(o_vpn[d]),  e_vpn[d]);
            chk(req,  $sformatf("w%0d out_data", nw[d]), int'(o_data[d]), e_data[d]);
            chk(lreq, $sformatf("w%0d lk_hit",   nw[d]), int'(lk_hit[d]), e_lkh[d]);
            chk(lreq, $sformatf("w%0d lk_data",  nw[d]), int'(lk_data[d]), e_lkd[d]);
        end
    endtask

    // One cycle: drive at the falling edge, predict, wait for the rising edge, check at the next falling edge.
    task automatic step(input int op, input int esel, input int vpn, input int vbit,
                        input int data, input int lkq, input int lvpn,
                        input string req, input string lreq);
        cmd_op   = 2'(op);
        cmd_esel = 4'(esel);
        cmd_vpn  = 20'(vpn);
        cmd_vbit = 1'(vbit);
        cmd_data = 16'(data);
        lk_req   = 1'(lkq);
        lk_vpn   = 20'(lvpn);
        for (int d = 0; d < 2; d++) begin
            int set, tag, way, lset, ltag, lw, sw;
            set  = vpn & 127;
            tag  = vpn >> 7;
            way  = esel & (nw[d] - 1);
            lset = lvpn & 127;
            ltag = lvpn >> 7;
            lw = -1;
            for (int w = nw[d] - 1; w >= 0; w--)
                if (mv[d][lset][w] != 0 && mt[d][lset][w] == ltag) lw = w;
            e_lkh[d] = (lkq != 0 && lw >= 0) ? 1 : 0;
            e_lkd[d] = e_lkh[d] ? md[d][lset][lw] : 0;
            case (op)
                1: begin
                    if (way == mp[d][set]) mp[d][set] = (mp[d][set] + 1) % nw[d];
                    mv[d][set][way] = vbit; mt[d][set][way] = tag; md[d][set][way] = data;
                    e_esel[d] = way; e_nv[d] = mp[d][set]; e_hit[d] = 0;
                    e_vbit[d] = vbit; e_vpn[d] = vpn; e_data[d] = data;
                end
                2: begin
                    e_esel[d] = way; e_nv[d] = mp[d][set]; e_hit[d] = 0;
                    e_vbit[d] = mv[d][set][way];
                    e_vpn[d]  = (mt[d][set][way] << 7) | set;
                    e_data[d] = md[d][set][way];
                end
                3: begin
                    sw = -1;
                    for (int w = nw[d] - 1; w >= 0; w--)
                        if (mv[d][set][w] != 0 && mt[d][set][w] == tag) sw = w;
                    e_nv[d] = mp[d][set]; e_vpn[d] = vpn;
                    if (sw >= 0) begin
                        e_esel[d] = sw; e_hit[d] = 1; e_vbit[d] = 1; e_data[d] = md[d][set][sw];
                    end else begin
                        e_esel[d] = mp[d][set]; e_hit[d] = 0; e_vbit[d] = 0; e_data[d] = 0;
                    end
                end
                default: begin
                    if (lkq != 0 && lw < 0) begin
                        e_esel[d] = mp[d][lset]; e_nv[d] = mp[d][lset]; e_hit[d] = 0;
                        e_vbit[d] = 0; e_vpn[d] = lvpn; e_data[d] = 0;
                    end
                end
            endcase
        end
        @(posedge clk);
        @(negedge clk);
        compare_all(req, lreq);
    endtask

    function automatic int pg(input int tag, input int set);
        return (tag << 7) | set;
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
            $finish;
        end
    end

    initial begin
        int lfsr;
        for (int d = 0; d < 2; d++) begin
            e_esel[d] = 0; e_nv[d] = 0; e_hit[d] = 0; e_vbit[d] = 0;
            e_vpn[d] = 0; e_data[d] = 0; e_lkh[d] = 0; e_lkd[d] = 0;
            for (int s = 0; s < 128; s++) begin
                mp[d][s] = 0;
                for (int w = 0; w < 4; w++) begin
                    mv[d][s][w] = 0; mt[d][s][w] = 0; md[d][s][w] = 0;
                end
            end
        end
        repeat (4) @(negedge clk);
        rst = 1'b0;
        compare_all("R1", "R1");                                  // R1: cleared outputs
        step(2, 2, pg(0, 3), 0, 0, 0, 0, "R1", "R1");             // R1: read of untouched entry
        step(0, 0, 0, 0, 0, 1, pg(5, 3), "R1", "R1");             // R1: lookup finds nothing

        // Writes into set 5 and pointer behaviour
        step(1, 0, pg('h11, 5), 1, 'hA0, 0, 0, "R3", "R2");        // R2/R3: fill pointed way 0
        step(1, 3, pg('h12, 5), 1, 'hA1, 0, 0, "R3", "R2");        // R3: off-pointer on 4 ways
        step(1, 'hD, pg('h13, 5), 1, 'hA2, 0, 0, "R10", "R10");    // R10: upper select bits ignored
        step(2, 1, pg(0, 5), 0, 0, 0, 0, "R4", "R4");              // R4: read back
        step(2, 'hB, pg(0, 5), 0, 0, 0, 0, "R10", "R10");          // R10: read with upper bits set
        step(3, 0, pg('h12, 5), 0, 0, 0, 0, "R5", "R5");           // R5: search hit
        step(3, 0, pg('h7F, 5), 0, 0, 0, 0, "R6", "R6");           // R6: search miss
        step(1, 2, pg('h20, 5), 0, 'hA3, 0, 0, "R2", "R2");        // R2: store invalid entry
        step(3, 0, pg('h20, 5), 0, 0, 0, 0, "R6", "R6");           // R6: invalid tag match misses

        // Translation port
        step(0, 0, 0, 0, 0, 1, pg('h11, 5), "R11", "R7");          // R7 hit; R11 outputs hold
        step(0, 0, 0, 0, 0, 1, pg('h55, 5), "R8", "R7");           // R8: lookup miss reported
        step(0, 0, 0, 0, 0, 0, 0, "R11", "R7");                    // R11: quiet cycle
        step(3, 0, pg('h11, 5), 0, 0, 1, pg('h66, 9), "R9", "R7"); // R9: search wins over miss
        step(2, 0, pg(0, 5), 0, 0, 1, pg('h66, 9), "R9", "R7");    // R9: read wins over miss
        step(1, 1, pg('h30, 6), 1, 'hB0, 1, pg('h30, 6), "R9", "R7"); // R7: old contents seen
        step(0, 0, 0, 0, 0, 1, pg('h30, 6), "R11", "R7");          // R7: now hits

        // Pointer wrap in set 9
        for (int i = 0; i < 4; i++)
            step(1, i, pg('h40 + i, 9), 1, 'hC0 + i, 0, 0, "R3", "R3");
        step(2, 0, pg(0, 9), 0, 0, 0, 0, "R3", "R3");

        // Duplicate tags: lowest way wins
        step(1, 2, pg('h77, 10), 1, 'hD2, 0, 0, "R2", "R2");
        step(1, 1, pg('h77, 10), 1, 'hD1, 0, 0, "R2", "R2");
        step(3, 0, pg('h77, 10), 0, 0, 1, pg('h77, 10), "R5", "R7");

        // Pseudo-random traffic over a few sets and tags
        lfsr = 32'h1ACE5EED;
        for (int n = 0; n < 600; n++) begin
            int op, lq;
            lfsr = (lfsr << 1) ^ ((lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]) ? 1 : 0);
            lfsr = lfsr ^ (lfsr >>> 7) ^ (lfsr << 9);
            op = lfsr & 3;
            lq = (lfsr >> 20) & 1;
            step(op, (lfsr >> 9) & 15, pg((lfsr >> 6) & 3, 20 + ((lfsr >> 3) & 1)),
                 (((lfsr >> 13) & 3) != 0) ? 1 : 0, (lfsr >> 14) & 'hFFFF,
                 lq, pg((lfsr >> 22) & 3, 20 + ((lfsr >> 24) & 1)),
                 op == 1 ? "R3" : op == 2 ? "R4" : op == 3 ? "R5" : "R8", "R7");
        end

        // Reset again mid-run
        rst = 1'b1;
        for (int d = 0; d < 2; d++) begin
            e_esel[d] = 0; e_nv[d] = 0; e_hit[d] = 0; e_vbit[d] = 0;
            e_vpn[d] = 0; e_data[d] = 0; e_lkh[d] = 0; e_lkd[d] = 0;
            for (int s = 0; s < 128; s++) begin
                mp[d][s] = 0;
                for (int w = 0; w < 4; w++) begin
                    mv[d][s][w] = 0; mt[d][s][w] = 0; md[d][s][w] = 0;
                end
            end
        end
        cmd_op = '0; lk_req = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        compare_all("R1", "R1");
        step(3, 0, pg('h11, 5), 0, 0, 0, 0, "R1", "R1");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, errors);
        $finish;
    end

endmodule